// File: doc/BRIEF.md
# Indexed Palette Register Port

This block is the colour lookup table of a display controller. It stores 256 colours, each made of an 8-bit red, an 8-bit green and an 8-bit blue component. Software loads the table through a small memory-mapped register window on a 32-bit write bus. A pixel pipeline reads the table at the same time through a dedicated lookup port.

Software first writes a starting entry number into the index register. It then writes colour bytes into the data register. Each data write fills the next component of the current entry: red, then green, then blue. After the blue component the entry number steps forward by one, so a whole ramp of colours can be streamed with a single index write. The colour byte always sits in the most significant byte of the bus word.

Each honoured data write produces a one-cycle change pulse, so that a display engine can schedule a redraw. Reads of the window always return zero.

Top module: `clut_regport`

## Requirements
- R1: After reset every entry reads 0x000000 except entry 255, which reads 0xFFFFFF. The current entry is 0 and the next data write fills the red component.
- R2: The register is selected by bus_addr[3:2], and bus_addr[1:0] is ignored. A write with select 0 loads the current entry from bus_wdata[31:24] and makes the next data write fill red.
- R3: Successive writes with select 1 store bus_wdata[31:24] into the red, then the green, then the blue component of the current entry.
- R4: The blue write advances the current entry by one, and entry 255 wraps to 0. The next data write then fills red again.
- R5: Writes with select 2 or 3 change no entry, no current entry and no component position, and raise no change pulse.
- R6: bus_rdata is zero at all times.
- R7: lu_rgb shows the entry that was on lu_idx at the previous rising clock edge. It is laid out as red in [23:16], green in [15:8] and blue in [7:0].
- R8: A write is honoured only when bus_be is 4'b1111 (full word) or 4'b1000 (top byte only). Any other mask leaves the block untouched.
- R9: pal_changed is high for exactly the one cycle after each honoured data-register write, and low otherwise.
- R10: A lookup issued in the same cycle as a write to that entry returns the old colour. The next lookup returns the new colour.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_wr_valid | input | 1 | Write strobe for the register window |
| bus_addr | input | 4 | Byte address within the 16-byte window |
| bus_wdata | input | 32 | Write data; the colour or index byte is in [31:24] |
| bus_be | input | 4 | Byte enables of the write |
| bus_rdata | output | 32 | Read data of the window, always zero |
| lu_idx | input | 8 | Entry number looked up by the pixel pipeline |
| lu_rgb | output | 24 | Registered colour of the looked-up entry |
| pal_changed | output | 1 | One-cycle pulse after each colour component write |

## Verification
The hardest states to reach are the hidden component position and the wrap of the current entry from 255 to 0, because neither is visible at the ports. The stimulus reaches them in two ways. It leaves a colour triple half written and then issues an index write, a stray write to select 2 or 3, or a write with a rejected byte mask. It then continues the sequence and reads back, through the lookup port, which component of which entry the next data write actually landed in. The same-cycle overlap of a blue write and a lookup of that entry is driven on purpose, to pin down the old-then-new read order.

// File: rtl/clut_pkg.sv
package clut_pkg;
  localparam int COMP_W     = 8;
  localparam int WIN_ADDR_W = 4;

  localparam logic [1:0] SEL_INDEX = 2'd0;
  localparam logic [1:0] SEL_DATA  = 2'd1;

  typedef enum logic [1:0] {
    STEP_RED = 2'd0,
    STEP_GRN = 2'd1,
    STEP_BLU = 2'd2
  } step_e;

  typedef struct packed {
    logic [COMP_W-1:0] r;
    logic [COMP_W-1:0] g;
    logic [COMP_W-1:0] b;
  } rgb_t;
endpackage

// File: rtl/clut_rst_sync.sv
module clut_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/clut_bus_decode.sv
module clut_bus_decode
  import clut_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                  wr_valid,
  input  logic [WIN_ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [DATA_W/8-1:0]   be,
  output logic                  idx_we,
  output logic                  dat_we,
  output logic [COMP_W-1:0]     wr_byte
);
  localparam int BE_W = DATA_W / 8;
  localparam logic [BE_W-1:0] BE_FULL = {BE_W{1'b1}};
  localparam logic [BE_W-1:0] BE_TOP  = {1'b1, {(BE_W-1){1'b0}}};

  logic       be_ok;
  logic [1:0] sel;
  logic       unused_bits;

  always_comb begin
    sel     = addr[3:2];
    be_ok   = (be == BE_FULL) || (be == BE_TOP);
    idx_we  = wr_valid && be_ok && (sel == SEL_INDEX);
    dat_we  = wr_valid && be_ok && (sel == SEL_DATA);
    wr_byte = wdata[DATA_W-1 -: COMP_W];
  end

  assign unused_bits = ^{addr[1:0], wdata[DATA_W-COMP_W-1:0]};
endmodule

// File: rtl/clut_seq.sv
module clut_seq
  import clut_pkg::*;
#(
  parameter int ENTRIES = 256,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idx_we,
  input  logic              dat_we,
  input  logic [COMP_W-1:0] wr_byte,
  output logic [IDX_W-1:0]  cur_idx,
  output logic [2:0]        comp_we,
  output logic              chg
);
  logic [IDX_W-1:0] idx_q, idx_d;
  step_e            step_q, step_d;
  logic             chg_q;
  logic             st_en;

  always_comb begin
    idx_d   = idx_q;
    step_d  = step_q;
    comp_we = 3'b000;
    st_en   = idx_we || dat_we;
    if (idx_we) begin
      idx_d  = IDX_W'(wr_byte);
      step_d = STEP_RED;
    end else if (dat_we) begin
      unique case (step_q)
        STEP_RED: begin comp_we = 3'b001; step_d = STEP_GRN; end
        STEP_GRN: begin comp_we = 3'b010; step_d = STEP_BLU; end
        STEP_BLU: begin
          comp_we = 3'b100;
          step_d  = STEP_RED;
          idx_d   = (idx_q == IDX_W'(ENTRIES-1)) ? '0 : idx_q + 1'b1;
        end
        default:  step_d = STEP_RED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      step_q <= STEP_RED;
    end else if (st_en) begin
      idx_q  <= idx_d;
      step_q <= step_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chg_q <= 1'b0;
    else        chg_q <= dat_we;
  end

  assign cur_idx = idx_q;
  assign chg     = chg_q;

  // R3: the component position never leaves red/green/blue
  assert_step_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step_q != step_e'(2'd3));

  // R2: an index write loads the byte and restarts at red
  assert_index_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    idx_we |=> (idx_q == IDX_W'($past(wr_byte))) && (step_q == STEP_RED));

  // R4: the blue write advances the entry (wrapping) and restarts at red
  assert_blue_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_we && step_q == STEP_BLU) |=>
      (idx_q == IDX_W'($past(idx_q) + 1'b1)) && (step_q == STEP_RED));
endmodule

// File: rtl/clut_store.sv
module clut_store
  import clut_pkg::*;
#(
  parameter int ENTRIES = 256,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [2:0]        comp_we,
  input  logic [COMP_W-1:0] wr_byte,
  input  logic [IDX_W-1:0]  lu_idx,
  output rgb_t              lu_rgb
);
  rgb_t ent_w [ENTRIES];
  rgb_t lu_q;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    localparam rgb_t RST_VAL = (i == ENTRIES-1) ? {3*COMP_W{1'b1}} : '0;
    rgb_t q;
    logic hit;

    assign hit = (wr_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= RST_VAL;
      end else begin
        if (hit && comp_we[0]) q.r <= wr_byte;
        if (hit && comp_we[1]) q.g <= wr_byte;
        if (hit && comp_we[2]) q.b <= wr_byte;
      end
    end

    assign ent_w[i] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lu_q <= '0;
    else        lu_q <= ent_w[lu_idx];
  end

  assign lu_rgb = lu_q;

  // R3: at most one component is written per cycle
  assert_one_comp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(comp_we));

  // R3: a red write lands in the addressed entry
  assert_red_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    comp_we[0] |=> ent_w[$past(wr_idx)].r == $past(wr_byte));
endmodule

// File: rtl/clut_regport.sv
module clut_regport
  import clut_pkg::*;
#(
  parameter int ENTRIES = 256,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int BE_W   = DATA_W / 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr_valid,
  input  logic [WIN_ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  input  logic [BE_W-1:0]       bus_be,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic [IDX_W-1:0]      lu_idx,
  output logic [3*COMP_W-1:0]   lu_rgb,
  output logic                  pal_changed
);
  logic              rst_sync_n;
  logic              idx_we, dat_we;
  logic [COMP_W-1:0] wr_byte;
  logic [IDX_W-1:0]  cur_idx;
  logic [2:0]        comp_we;
  rgb_t              lu_word;

  clut_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  clut_bus_decode #(.DATA_W(DATA_W)) u_dec (
    .wr_valid (bus_wr_valid),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .be       (bus_be),
    .idx_we   (idx_we),
    .dat_we   (dat_we),
    .wr_byte  (wr_byte)
  );

  clut_seq #(.ENTRIES(ENTRIES)) u_seq (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .idx_we  (idx_we),
    .dat_we  (dat_we),
    .wr_byte (wr_byte),
    .cur_idx (cur_idx),
    .comp_we (comp_we),
    .chg     (pal_changed)
  );

  clut_store #(.ENTRIES(ENTRIES)) u_store (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_idx  (cur_idx),
    .comp_we (comp_we),
    .wr_byte (wr_byte),
    .lu_idx  (lu_idx),
    .lu_rgb  (lu_word)
  );

  assign lu_rgb    = lu_word;
  assign bus_rdata = '0;

  // R5: writes to select 2 or 3 leave the current entry alone and raise no pulse
  assert_spare_ignored_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr_valid && bus_addr[3]) |=> ($stable(cur_idx) && !pal_changed));

  // R9: a change pulse is always preceded by an honoured data write
  assert_chg_source_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pal_changed |-> $past(bus_wr_valid && bus_addr[3:2] == SEL_DATA &&
                          (bus_be == {BE_W{1'b1}} || bus_be == {1'b1, {(BE_W-1){1'b0}}})));
endmodule

// File: tb/clut_regport_tb.sv
module clut_regport_tb;
  localparam int CLK_P = 10;

  typedef struct {
    int          kind;   // 0 lookup colour, 1 change pulse
    logic [23:0] exp;
    int          due;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr_valid = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  lu_idx = '0;
  logic [23:0] lu_rgb;
  logic        pal_changed;

  int checks = 0, errors = 0, cyc = 0;
  item_t q[$];
  logic [7:0] mr[256], mg[256], mb[256];
  logic [7:0] midx;
  int mstep;

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  clut_regport u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr_valid(bus_wr_valid), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
    .lu_idx(lu_idx), .lu_rgb(lu_rgb), .pal_changed(pal_changed)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expectations when their cycle arrives
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      it = q.pop_front();
      if (it.kind == 0) check(it.tag, {8'h0, lu_rgb}, {8'h0, it.exp});
      else              check(it.tag, {31'h0, pal_changed}, {31'h0, it.exp[0]});
    end
  end

  function automatic logic [23:0] model_rgb(input logic [7:0] i);
    return {mr[i], mg[i], mb[i]};
  endfunction

  function automatic void model_write(input logic [3:0] a, input logic [31:0] d,
                                      input logic [3:0] be, output logic chg);
    logic hon;
    logic [7:0] b;
    hon = (be == 4'hF) || (be == 4'h8);
    b   = d[31:24];
    chg = 1'b0;
    if (hon && a[3:2] == 2'd0) begin
      midx = b; mstep = 0;
    end else if (hon && a[3:2] == 2'd1) begin
      chg = 1'b1;
      case (mstep)
        0: mr[midx] = b;
        1: mg[midx] = b;
        default: mb[midx] = b;
      endcase
      if (mstep == 2) begin midx = midx + 8'd1; mstep = 0; end
      else mstep++;
    end
  endfunction

  // driver: a write, optionally with a lookup in the same cycle
  task automatic drive(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be,
                       input logic do_lu, input logic [7:0] li, input string tag);
    item_t it;
    logic chg;
    @(negedge clk);
    bus_wr_valid = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    if (do_lu) begin
      lu_idx = li;
      it = '{kind: 0, exp: model_rgb(li), due: cyc + 1, tag: {"R7/R10 ", tag}};
      q.push_back(it);
    end
    check({"R6 rdata ", tag}, bus_rdata, 32'h0);
    model_write(a, d, be, chg);
    it = '{kind: 1, exp: {23'h0, chg}, due: cyc + 1, tag: {"R9 pulse ", tag}};
    q.push_back(it);
    @(posedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be,
                    input string tag);
    drive(a, d, be, 1'b0, 8'h0, tag);
  endtask

  task automatic look(input logic [7:0] li, input string tag);
    item_t it;
    @(negedge clk);
    bus_wr_valid = 1'b0;
    lu_idx = li;
    it = '{kind: 0, exp: model_rgb(li), due: cyc + 1, tag: {"R7/", tag}};
    q.push_back(it);
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      bus_wr_valid = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mr[i] = (i == 255) ? 8'hFF : 8'h00;
      mg[i] = mr[i];
      mb[i] = mr[i];
    end
    midx = 8'h0; mstep = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    check("R1 pulse low after reset", {31'h0, pal_changed}, 32'h0);

    // R1 reset contents
    look(8'h00, "R1 entry0");
    look(8'h80, "R1 entry128");
    look(8'hFE, "R1 entry254");
    look(8'hFF, "R1 entry255 white");

    // R3 triple from the reset index
    wr(4'h4, 32'h1100_0000, 4'hF, "R3 red");
    wr(4'h4, 32'h2200_0000, 4'hF, "R3 green");
    wr(4'h4, 32'h3300_0000, 4'hF, "R3 blue");
    look(8'h00, "R3 entry0 full");
    wr(4'h5, 32'hAA00_0000, 4'h8, "R8 top-byte red");
    look(8'h01, "R3/R8 entry1 red");

    // R2 index load, low address bits ignored, step restart
    wr(4'h3, 32'hFE12_3456, 4'hF, "R2 index FE");
    wr(4'h4, 32'h5A00_0000, 4'hF, "R2 red FE");
    wr(4'h0, 32'h1000_0000, 4'hF, "R2 index 10");
    wr(4'h4, 32'h0100_0000, 4'hF, "R2 red 10");
    wr(4'h4, 32'h0200_0000, 4'hF, "R2 green 10");
    wr(4'h4, 32'h0300_0000, 4'hF, "R2 blue 10");
    look(8'h10, "R2 entry10");
    look(8'hFE, "R2 entryFE partial");
    look(8'h01, "R2 entry1 untouched");

    // R4 wrap from 255 to 0
    wr(4'h0, 32'hFF00_0000, 4'hF, "R4 index FF");
    wr(4'h4, 32'hC100_0000, 4'hF, "R4 red FF");
    wr(4'h4, 32'hC200_0000, 4'hF, "R4 green FF");
    wr(4'h4, 32'hC300_0000, 4'hF, "R4 blue FF");
    wr(4'h4, 32'h7700_0000, 4'hF, "R4 red after wrap");
    look(8'hFF, "R4 entryFF");
    look(8'h00, "R4 entry0 red after wrap");

    // R5 spare selects
    wr(4'h8, 32'hEE00_0000, 4'hF, "R5 sel2");
    wr(4'hC, 32'hEE00_0000, 4'hF, "R5 sel3");
    wr(4'hB, 32'h0000_0000, 4'hF, "R5 sel2 index-like");
    wr(4'h4, 32'h8800_0000, 4'hF, "R5 green continues");
    look(8'h00, "R5 entry0 green");

    // R8 rejected byte masks
    wr(4'h4, 32'hDD00_0000, 4'h4, "R8 be4");
    wr(4'h4, 32'hDD00_0000, 4'h1, "R8 be1");
    wr(4'h4, 32'hDD00_0000, 4'h3, "R8 be3");
    wr(4'h4, 32'hDD00_0000, 4'hC, "R8 beC");
    wr(4'h4, 32'hDD00_0000, 4'h0, "R8 be0");
    wr(4'h0, 32'h4000_0000, 4'h7, "R8 index be7");
    wr(4'h4, 32'h9900_0000, 4'hF, "R8 blue continues");
    look(8'h00, "R8 entry0 complete");
    wr(4'h4, 32'h5500_0000, 4'hF, "R8 red entry1");
    look(8'h01, "R8 entry1");
    look(8'h40, "R8 entry40 untouched");

    // R10 write and lookup of the same entry in one cycle
    wr(4'h0, 32'h2000_0000, 4'hF, "R10 index 20");
    wr(4'h4, 32'h1000_0000, 4'hF, "R10 red");
    wr(4'h4, 32'h2000_0000, 4'hF, "R10 green");
    drive(4'h4, 32'h3000_0000, 4'hF, 1'b1, 8'h20, "R10 old value");
    look(8'h20, "R10 new value");

    idle(4);
    finish_run();
  end
endmodule